// File: doc/BRIEF.md
# Depth-Chained FIFO Ring with Token Hand-Off

The block joins `SLICES` identical FIFO slices, each `DEPTH` words of `WIDTH` bits, into one buffer of `SLICES*DEPTH` words. Every slice sees the same write strobe, read strobe and data input. At any time one slice holds the write token and accepts writes. One slice, which may be a different one, holds the read token and supplies reads. When the write owner fills its top address, it raises a write-pass strobe toward the next slice in the ring, and that slice owns the write side from the following clock. The read side moves on in the same way. The hand-off costs no cycle, so back-to-back strobes cross slice boundaries with no gap.

Write passing and read passing use separate strobes, so two hand-offs can happen in the same clock without mixing them up. A small flag-merge stage builds the composite full, empty and half-full flags from the per-slice flags. Each slice drives zero on its data output unless it supplied the last read, and the merged output is the OR of all slice outputs.

At reset the block samples `expand_i`. If it is high, the slices work as a ring and slice `FIRST_LOAD` starts with both tokens. If it is low, slice 0 runs alone as a plain `DEPTH`-word FIFO. In that mode the half-full flag and the read-pointer rewind are active, and the other slices stay idle.

Top module: `fifo_depth_ring`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `empty_no` is 0, `full_no` is 1, `half_no` is 1 and `dout_o` is 0.
- R2: Words are read out in the order they were written. A read accepted at one clock edge presents its word on `dout_o` after that edge. Back-to-back strobes continue across slice boundaries with no idle cycle.
- R3: In ring mode, `xo_wr_o[k]` is 1 during the cycle in which an accepted write goes into address `DEPTH-1` of slice k. It is 0 at all other times.
- R4: In ring mode, `xo_rd_o[k]` is 1 during the cycle in which an accepted read takes the word at address `DEPTH-1` of slice k. It is 0 at all other times.
- R5: After a reset in ring mode, slice `FIRST_LOAD` (default 0) owns both tokens, so it takes the first `DEPTH` writes. Exactly one slice owns each token at every cycle.
- R6: `full_no` is 0 exactly when every slice is full (`SLICES*DEPTH` words in ring mode, `DEPTH` in single mode). A write strobe while full changes nothing.
- R7: `empty_no` is 0 exactly when no word is held. A read strobe while empty removes nothing, and `dout_o` is 0 after that edge.
- R8: `dout_o` is the OR of the slice outputs, and at most one slice output is non-zero at any time.
- R9: With `expand_i` low during reset, the block holds `DEPTH` words in slice 0 and both `xo_wr_o` and `xo_rd_o` stay 0.
- R10: `half_no` is 0 exactly when the block is in single mode and holds more than `DEPTH/2` words. In ring mode it stays 1.
- R11: In single mode, a cycle with `rt_i` high rewinds reading to the first word written since reset, and all stored words become readable again. This holds as long as no more than `DEPTH` writes have occurred since reset. In ring mode `rt_i` has no effect.
- R12: A write and a read in the same cycle both take effect. A write-token pass and a read-token pass in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; the mode and the first owner are sampled on clock edges while it is low |
| expand_i | input | 1 | Mode select sampled during reset: 1 = ring of slices, 0 = slice 0 alone |
| wr_i | input | 1 | Shared write strobe, one word per cycle |
| din_i | input | WIDTH | Write data |
| rd_i | input | 1 | Shared read strobe, one word per cycle |
| rt_i | input | 1 | Read rewind, active in single mode only |
| dout_o | output | WIDTH | Merged read data |
| full_no | output | 1 | Composite full, active low |
| empty_no | output | 1 | Composite empty, active low |
| half_no | output | 1 | More than half full, active low, single mode only |
| xo_wr_o | output | SLICES | Per-slice write-token pass strobes |
| xo_rd_o | output | SLICES | Per-slice read-token pass strobes |

## Verification
Two events can fall in the same clock. One is the write side leaving a slice while the read side leaves another slice. The other is a write and a read accepted together. The bench first fills the ring with exactly `DEPTH` words and then issues simultaneous read and write strobes. This puts the write index and the read index on slice boundaries in the same cycle. Both pass strobes are compared with the slice positions the bench computes from its own running write and read counts. The data stream is compared against a reference queue, so a dropped or duplicated hand-off shows up as a miscompare.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
  } xfer_t;
endpackage

// File: rtl/fifo_slice_ram.sv
module fifo_slice_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic             clr_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // non-owning slices park at zero so the merged bus can be an OR
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (re_i)  rdata_q <= mem_q[raddr_i];
    else if (clr_i) rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fifo_ring_slice.sv
module fifo_ring_slice
  import fifo_ring_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xi_level_i,
  input  logic             first_ni,
  input  xfer_t            take_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             rt_i,
  input  logic [WIDTH-1:0] din_i,
  output xfer_t            pass_o,
  output logic [WIDTH-1:0] dout_o,
  output logic             wtok_o,
  output logic             rtok_o,
  output logic             single_o,
  output logic             full_no,
  output logic             empty_no,
  output logic             half_no
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          single_q, wtok_q, rtok_q;
  logic [PW-1:0] wptr_q, rptr_q, fill;
  logic          full, empty, wr_en, rd_en, rewind;

  assign fill   = wptr_q - rptr_q;
  assign full   = (fill == PW'(DEPTH));
  assign empty  = (fill == '0);
  assign wr_en  = wr_i & (single_q | wtok_q) & ~full;
  assign rd_en  = rd_i & (single_q | rtok_q) & ~empty;
  assign rewind = single_q & rt_i;

  assign pass_o.wr = ~single_q & wr_en & (wptr_q[AW-1:0] == LAST);
  assign pass_o.rd = ~single_q & rd_en & (rptr_q[AW-1:0] == LAST);

  // mode and first owner are sampled on clock edges while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      single_q <= ~xi_level_i;
      wtok_q   <= ~first_ni;
      rtok_q   <= ~first_ni;
    end else begin
      wtok_q <= (wtok_q & ~pass_o.wr) | take_i.wr;
      rtok_q <= (rtok_q & ~pass_o.rd) | take_i.rd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_en)       wptr_q <= wptr_q + PW'(1);
      if (rewind)      rptr_q <= '0;
      else if (rd_en)  rptr_q <= rptr_q + PW'(1);
    end
  end

  fifo_slice_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wptr_q[AW-1:0]),
    .wdata_i (din_i),
    .re_i    (rd_en),
    .clr_i   (rd_i & ~rd_en),
    .raddr_i (rptr_q[AW-1:0]),
    .rdata_o (dout_o)
  );

  assign wtok_o   = wtok_q;
  assign rtok_o   = rtok_q;
  assign single_o = single_q;
  assign full_no  = ~full;
  assign empty_no = ~empty;
  assign half_no  = ~(single_q & (fill > PW'(DEPTH / 2)));

  AST_WTOK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o.wr |=> !wtok_q); // R3
  AST_RTOK_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i.rd |=> rtok_q); // R4
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !rd_i && !rt_i) |=> $stable(wptr_q) && $stable(rptr_q)); // R6
endmodule

// File: rtl/fifo_flag_merge.sv
module fifo_flag_merge #(
  parameter int SLICES = 3
) (
  input  logic              single_i,
  input  logic [SLICES-1:0] full_n_i,
  input  logic [SLICES-1:0] empty_n_i,
  input  logic              half_n_i,
  output logic              full_no,
  output logic              empty_no,
  output logic              half_no
);
  // ring: composite asserts only when every slice asserts (OR of active-low levels)
  assign full_no  = single_i ? full_n_i[0]  : |full_n_i;
  assign empty_no = single_i ? empty_n_i[0] : |empty_n_i;
  assign half_no  = single_i ? half_n_i     : 1'b1;
endmodule

// File: rtl/fifo_depth_ring.sv
module fifo_depth_ring
  import fifo_ring_pkg::*;
#(
  parameter int SLICES     = 3,
  parameter int DEPTH      = 512,
  parameter int WIDTH      = 9,
  parameter int FIRST_LOAD = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expand_i,
  input  logic              wr_i,
  input  logic [WIDTH-1:0]  din_i,
  input  logic              rd_i,
  input  logic              rt_i,
  output logic [WIDTH-1:0]  dout_o,
  output logic              full_no,
  output logic              empty_no,
  output logic              half_no,
  output logic [SLICES-1:0] xo_wr_o,
  output logic [SLICES-1:0] xo_rd_o
);
  xfer_t             pass_s [SLICES];
  logic [WIDTH-1:0]  dout_s [SLICES];
  logic [SLICES-1:0] wtok_v, rtok_v, single_v, full_v, empty_v, half_v, busy_v;

  for (genvar j = 0; j < SLICES; j++) begin : g_slice
    localparam int PREV = (j + SLICES - 1) % SLICES;
    logic xi_level;
    assign xi_level = (j == 0) ? expand_i : 1'b1;

    fifo_ring_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .xi_level_i (xi_level),
      .first_ni   (!((j == FIRST_LOAD) && expand_i)),
      .take_i     (pass_s[PREV]),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .rt_i       (rt_i),
      .din_i      (din_i),
      .pass_o     (pass_s[j]),
      .dout_o     (dout_s[j]),
      .wtok_o     (wtok_v[j]),
      .rtok_o     (rtok_v[j]),
      .single_o   (single_v[j]),
      .full_no    (full_v[j]),
      .empty_no   (empty_v[j]),
      .half_no    (half_v[j])
    );

    assign xo_wr_o[j] = pass_s[j].wr;
    assign xo_rd_o[j] = pass_s[j].rd;
    assign busy_v[j]  = |dout_s[j];
  end

  always_comb begin
    dout_o = '0;
    for (int j = 0; j < SLICES; j++) dout_o = dout_o | dout_s[j];
  end

  fifo_flag_merge #(.SLICES(SLICES)) i_merge (
    .single_i  (single_v[0]),
    .full_n_i  (full_v),
    .empty_n_i (empty_v),
    .half_n_i  (half_v[0]),
    .full_no   (full_no),
    .empty_no  (empty_no),
    .half_no   (half_no)
  );

  AST_WTOK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_v[0] |-> $countones(wtok_v) == 1); // R5
  AST_RTOK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_v[0] |-> $countones(rtok_v) == 1); // R5
  AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_v)); // R8
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_no) |=> dout_o == '0); // R7
endmodule

// File: tb/test_fifo_depth_ring.sv
module test_fifo_depth_ring;
  localparam int DEPTH = 512;
  localparam int N     = 3;
  localparam int W     = 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0, expand_i = 1'b1, wr_i = 1'b0, rd_i = 1'b0, rt_i = 1'b0;
  logic [W-1:0] din_i = '0;
  logic [W-1:0] dout_o;
  logic full_no, empty_no, half_no;
  logic [N-1:0] xo_wr_o, xo_rd_o;

  always #10 clk_i = ~clk_i;

  fifo_depth_ring #(.SLICES(N), .DEPTH(DEPTH), .WIDTH(W), .FIRST_LOAD(0)) i_fifo_depth_ring (
    .clk_i, .rst_ni, .expand_i, .wr_i, .din_i, .rd_i, .rt_i,
    .dout_o, .full_no, .empty_no, .half_no, .xo_wr_o, .xo_rd_o
  );

  int vectors = 0, fails = 0;
  logic [W-1:0] hist [$];
  int rd_idx = 0, cnt = 0, cnt_q = 0, pend = 0, pend_q = 0;
  bit single_m = 1'b0, mon_en = 1'b0;
  logic [W-1:0] exp_d = '0, exp_q = '0;
  string tag = "R2";

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard and checks flags one edge after each strobe
  always @(posedge clk_i) begin
    pend_q <= pend;
    exp_q  <= exp_d;
    cnt_q  <= cnt;
  end

  always @(negedge clk_i) begin
    if (rst_ni && mon_en) begin
      int cap;
      cap = single_m ? DEPTH : N * DEPTH;
      check(full_no  == !(cnt_q == cap), "R6 full", full_no, !(cnt_q == cap));
      check(empty_no == !(cnt_q == 0), "R7 empty", empty_no, !(cnt_q == 0));
      check(half_no  == !(single_m && cnt_q > DEPTH / 2), "R10 half", half_no,
            !(single_m && cnt_q > DEPTH / 2));
      if (pend_q == 1) check(dout_o == exp_q, tag, dout_o, exp_q);
      if (pend_q == 2) check(dout_o == '0, "R7 empty read", dout_o, 0);
    end
  end

  // driver: applies one strobe pair and pushes the expected word
  task automatic op(bit w, bit r, logic [W-1:0] d);
    int cap;
    bit wacc, racc;
    logic [N-1:0] xw, xr;
    @(negedge clk_i);
    wr_i = w; rd_i = r; din_i = d; rt_i = 1'b0;
    cap  = single_m ? DEPTH : N * DEPTH;
    wacc = w && cnt < cap;
    racc = r && cnt > 0;
    xw = '0; xr = '0;
    if (wacc && !single_m && (hist.size() % DEPTH) == DEPTH - 1)
      xw[(hist.size() / DEPTH) % N] = 1'b1;
    if (racc && !single_m && (rd_idx % DEPTH) == DEPTH - 1)
      xr[(rd_idx / DEPTH) % N] = 1'b1;
    #1;
    check(xo_wr_o == xw, "R3 R5 R9 write pass", xo_wr_o, xw);
    check(xo_rd_o == xr, "R4 read pass", xo_rd_o, xr);
    pend = racc ? 1 : (r ? 2 : 0);
    if (racc) begin
      exp_d = hist[rd_idx];
      rd_idx++;
    end
    if (wacc) hist.push_back(d);
    cnt = cnt + int'(wacc) - int'(racc);
  endtask

  task automatic rewind();
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0; rt_i = 1'b1; pend = 0;
    if (single_m) begin
      rd_idx = 0;
      cnt = hist.size();
    end
    #1;
    check(xo_wr_o == '0 && xo_rd_o == '0, "R11 no pass on rewind", xo_wr_o, 0);
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk_i);
    mon_en = 1'b0;
    rst_ni = 1'b0; expand_i = mode; wr_i = 1'b0; rd_i = 1'b0; rt_i = 1'b0;
    hist.delete(); rd_idx = 0; cnt = 0; pend = 0; single_m = !mode;
    repeat (3) @(negedge clk_i);
    check(empty_no == 1'b0 && full_no == 1'b1 && half_no == 1'b1 && dout_o == '0,
          "R1 in reset", {empty_no, full_no, half_no}, 3'b011);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(empty_no == 1'b0 && full_no == 1'b1 && half_no == 1'b1 && dout_o == '0,
          "R1 after reset", {empty_no, full_no, half_no}, 3'b011);
    mon_en = 1'b1;
  endtask

  function automatic logic [W-1:0] pat(int i);
    return W'(i * 37 + 5);
  endfunction

  initial begin
    // ring: fill whole, overfill, drain, empty read
    do_reset(1'b1);
    tag = "R2";
    for (int i = 0; i < N * DEPTH; i++) op(1'b1, 1'b0, pat(i));
    op(1'b1, 1'b0, 9'h1aa);            // R6 dropped
    for (int i = 0; i < N * DEPTH; i++) op(1'b0, 1'b1, '0);
    op(1'b0, 1'b1, '0);                // R7 empty read
    op(1'b0, 0, '0);
    // R12: concurrent traffic with offset, then R11 rewind ignored in ring mode
    tag = "R12";
    for (int i = 0; i < 700; i++) op(1'b1, 1'b0, pat(i + 3));
    for (int i = 0; i < 2000; i++) op(1'b1, 1'b1, pat(i + 900));
    rewind();
    tag = "R11 ring rewind ignored";
    for (int i = 0; i < 701; i++) op(1'b0, 1'b1, '0);
    // R12: offset of DEPTH so both passes land in one cycle
    tag = "R12 same-cycle pass";
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, pat(i + 11));
    for (int i = 0; i < 1200; i++) op(1'b1, 1'b1, pat(i + 77));
    for (int i = 0; i < DEPTH + 1; i++) op(1'b0, 1'b1, '0);
    // R9 single mode with R10 half flag and R11 rewind
    do_reset(1'b0);
    tag = "R9 single";
    for (int i = 0; i < DEPTH + 8; i++) op(1'b1, 1'b0, pat(i + 200));
    for (int i = 0; i < 100; i++) op(1'b0, 1'b1, '0);
    rewind();
    tag = "R11 single rewind";
    for (int i = 0; i < DEPTH + 1; i++) op(1'b0, 1'b1, '0);
    op(1'b0, 1'b0, '0);
    op(1'b0, 1'b0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule